// File: doc/BRIEF.md
# Multi-Source Sleep Wake-Up Controller

This block keeps a low-power device asleep and decides when it wakes. It runs on the fast system clock. Time while asleep is measured in ticks of a slow on-chip oscillator, whose rate depends on process and lies somewhere between 7 and 13 kHz. Each tick reaches the block as a one-cycle `slow_tick` strobe that has already been synchronised to the system clock. The block has three wake sources, and each one has its own enable:

- a wake pin held high;
- the SPI chip-select held low;
- a sleep countdown that expires.

A level source only counts after its level has held for `QUAL_TICKS` consecutive ticks. The default of 5 ticks stands for roughly half a millisecond.

A one-cycle `sleep_req` sends the awake device to sleep and loads the countdown from `sleep_time`. When a wake source qualifies on a tick, the block leaves sleep, which returns the device to its initial state. It then pulses `wake_event` for one cycle and records which source fired in `wake_cause`. That code holds until the next wake. Later state changes after waking are left to the rest of the device.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `asleep`, `wake_event` and `wake_cause` are all 0.
- R2: While awake, `sleep_req` high at a clock edge makes `asleep` 1 after that edge. The same edge loads the countdown with `sleep_time` and clears both level qualifiers.
- R3: With `en_pin` set, `wake_pin` sampled high on `QUAL_TICKS` consecutive ticks wakes the device on the last of those ticks, with `wake_cause` = 1.
- R4: With `en_cs` set, `cs_n` sampled low on `QUAL_TICKS` consecutive ticks wakes the device on the last of those ticks, with `wake_cause` = 2.
- R5: A tick on which a qualifying level is absent restarts that qualifier's count from zero.
- R6: With `en_tmr` set, the countdown wakes the device on tick number max(`sleep_time`, 1) after sleep entry, with `wake_cause` = 3.
- R7: A source whose enable is clear never wakes the device. With all three enables clear, the device stays asleep indefinitely.
- R8: When several sources qualify on the same tick, the cause reported is the pin (1) over chip-select (2) over timer (3).
- R9: A wake makes `asleep` 0 and `wake_event` 1 for exactly one cycle after the qualifying tick's edge. `wake_cause` then holds its value until the next wake.
- R10: While awake, pin, chip-select and tick activity produce no `wake_event`.
- R11: While asleep, the device leaves sleep only on a cycle in which `slow_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow oscillator period |
| sleep_req | input | 1 | Request to enter sleep (used only while awake) |
| en_pin | input | 1 | Enable for the wake pin source |
| en_cs | input | 1 | Enable for the chip-select source |
| en_tmr | input | 1 | Enable for the countdown source |
| wake_pin | input | 1 | Wake pin level, active high |
| cs_n | input | 1 | SPI chip-select level, active low |
| sleep_time | input | SLP_W | Countdown load value, in ticks |
| asleep | output | 1 | High while the device is held in sleep |
| wake_event | output | 1 | One-cycle pulse when a wake is accepted |
| wake_cause | output | 2 | Last wake source: 1 pin, 2 chip-select, 3 timer |

## Verification
Faults inside this block surface at the ports in two ways. A qualifier count that is off by one shows up as a wake exactly one tick early or late. A countdown that is loaded or decremented wrongly moves the timer wake by the same tick offset. To expose these, `asleep` is sampled just before and just after the qualifying tick. A broken priority encoding or a stale enable shows up as the wrong `wake_cause` in the very cycle `wake_event` pulses. A stuck state shows up as a missing pulse or an unexpected one, which the scoreboard queue catches on the same cycle.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int QUAL_TICKS = 5,
  parameter int SLP_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             sleep_req,
  input  logic             en_pin,
  input  logic             en_cs,
  input  logic             en_tmr,
  input  logic             wake_pin,
  input  logic             cs_n,
  input  logic [SLP_W-1:0] sleep_time,
  output logic             asleep,
  output logic             wake_event,
  output logic [1:0]       wake_cause
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

  logic [QW-1:0]    pin_q, cs_q;
  logic [SLP_W-1:0] tmr;

  wire pin_lvl = en_pin & wake_pin;
  wire cs_lvl  = en_cs & ~cs_n;
  wire pin_hit = pin_lvl && (pin_q == QLAST);
  wire cs_hit  = cs_lvl && (cs_q == QLAST);
  wire tmr_hit = en_tmr && (tmr <= SLP_W'(1));
  wire wake    = asleep && slow_tick && (pin_hit || cs_hit || tmr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      wake_event <= 1'b0;
      wake_cause <= 2'd0;
      pin_q      <= '0;
      cs_q       <= '0;
      tmr        <= '0;
    end else begin
      wake_event <= wake;
      if (wake) begin
        asleep     <= 1'b0;
        wake_cause <= pin_hit ? 2'd1 : (cs_hit ? 2'd2 : 2'd3);
      end else if (!asleep && sleep_req) begin
        asleep <= 1'b1;
        tmr    <= sleep_time;
        pin_q  <= '0;
        cs_q   <= '0;
      end else if (asleep && slow_tick) begin
        pin_q <= pin_lvl ? pin_q + QW'(1) : '0;
        cs_q  <= cs_lvl ? cs_q + QW'(1) : '0;
        if (tmr != '0) tmr <= tmr - SLP_W'(1);
      end
    end
  end

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_event |=> !wake_event);
  // R9
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_event |-> (!asleep && $past(asleep)));
  // R11
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !slow_tick) |=> asleep);
  // R7
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !en_pin && !en_cs && !en_tmr) |=> asleep);
  // R3
  cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_event |-> (wake_cause != 2'd0));
  // R10
  awake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |=> !wake_event);
  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && sleep_req) |=> asleep);
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
  localparam int QT = 5;
  localparam int SW = 16;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, sleep_req = 1'b0;
  logic en_pin = 1'b0, en_cs = 1'b0, en_tmr = 1'b0, wake_pin = 1'b0, cs_n = 1'b1;
  logic [SW-1:0] sleep_time = '0;
  logic asleep, wake_event;
  logic [1:0] wake_cause;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int exp_q[$];

  sleep_wake_ctrl #(.QUAL_TICKS(QT), .SLP_W(SW)) u_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sleep_req(sleep_req),
    .en_pin(en_pin), .en_cs(en_cs), .en_tmr(en_tmr), .wake_pin(wake_pin),
    .cs_n(cs_n), .sleep_time(sleep_time), .asleep(asleep),
    .wake_event(wake_event), .wake_cause(wake_cause));

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wake_event) begin
      if (exp_q.size() == 0) check("R10 unexpected wake", 1, 0);
      else check("R8/R9 wake_cause", int'(wake_cause), exp_q.pop_front());
    end
  end

  task automatic expect_wake(int cause);
    exp_q.push_back(cause);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_tick = 1'b1;
      @(negedge clk) slow_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic go_sleep(int st);
    @(negedge clk) begin sleep_time = SW'(st); sleep_req = 1'b1; end
    @(negedge clk) sleep_req = 1'b0;
    check("R2 asleep after request", int'(asleep), 1);
  endtask

  task automatic quiet();
    @(negedge clk) begin en_pin = 0; en_cs = 0; en_tmr = 0; wake_pin = 0; cs_n = 1; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 asleep", int'(asleep), 0);
    check("R1 wake_event", int'(wake_event), 0);
    check("R1 wake_cause", int'(wake_cause), 0);
    rst_n = 1'b1;

    // R3 pin wake
    go_sleep(100);
    @(negedge clk) begin en_pin = 1; wake_pin = 1; end
    ticks(QT - 1);
    check("R3 still asleep before last tick", int'(asleep), 1);
    expect_wake(1);
    ticks(1);
    check("R3 awake after qualifying tick", int'(asleep), 0);
    repeat (10) @(negedge clk);
    check("R9 cause holds", int'(wake_cause), 1);
    check("R9 pulse gone", int'(wake_event), 0);

    // R10 activity while awake
    ticks(12);
    check("R10 stays awake", int'(asleep), 0);
    quiet();

    // R5 drop restarts count
    go_sleep(100);
    @(negedge clk) begin en_pin = 1; wake_pin = 1; end
    ticks(QT - 2);
    @(negedge clk) wake_pin = 0;
    ticks(1);
    @(negedge clk) wake_pin = 1;
    ticks(QT - 1);
    check("R5 restart keeps asleep", int'(asleep), 1);
    expect_wake(1);
    ticks(1);
    check("R5 wake after full run", int'(asleep), 0);
    quiet();

    // R4 chip-select wake
    go_sleep(100);
    @(negedge clk) begin en_cs = 1; cs_n = 0; end
    ticks(QT - 1);
    check("R4 still asleep", int'(asleep), 1);
    expect_wake(2);
    ticks(1);
    check("R4 awake", int'(asleep), 0);
    quiet();

    // R6 timer wake
    @(negedge clk) en_tmr = 1;
    go_sleep(3);
    ticks(2);
    check("R6 asleep before expiry", int'(asleep), 1);
    expect_wake(3);
    ticks(1);
    check("R6 awake at expiry", int'(asleep), 0);
    go_sleep(0);
    expect_wake(3);
    ticks(1);
    check("R6 zero time wakes on first tick", int'(asleep), 0);
    quiet();

    // R7 disabled sources
    @(negedge clk) begin wake_pin = 1; cs_n = 0; end
    go_sleep(1);
    ticks(20);
    check("R7 all disabled stays asleep", int'(asleep), 1);
    @(negedge clk) en_cs = 1;
    ticks(QT - 1);
    check("R7 disabled pin ignored", int'(asleep), 1);
    expect_wake(2);
    ticks(1);
    check("R7 enabled cs wakes", int'(asleep), 0);
    quiet();

    // R8 priority
    @(negedge clk) begin en_pin = 1; en_cs = 1; en_tmr = 1; wake_pin = 1; cs_n = 0; end
    go_sleep(QT);
    expect_wake(1);
    ticks(QT);
    check("R8 all three same tick", int'(wake_cause), 1);
    quiet();
    @(negedge clk) begin en_cs = 1; en_tmr = 1; cs_n = 0; end
    go_sleep(QT);
    expect_wake(2);
    ticks(QT);
    check("R8 cs over timer", int'(wake_cause), 2);
    quiet();

    // R11 no wake without a tick
    go_sleep(100);
    @(negedge clk) begin en_pin = 1; wake_pin = 1; end
    ticks(QT - 1);
    repeat (50) @(negedge clk);
    check("R11 asleep without tick", int'(asleep), 1);
    expect_wake(1);
    ticks(1);
    check("R11 wakes on tick", int'(asleep), 0);
    quiet();

    repeat (5) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule